// File: doc/BRIEF.md
# Processor Status Register with Exception Gating

This block holds the 32-bit status word of a small CPU core and the logic that depends on it. It decodes the instruction being issued to find floating-point operations. It raises a fault when the floating-point unit is switched off, and it tells a fault outside a branch delay slot apart from one inside it. It compares incoming interrupt requests against the interrupt mask field of the status word.

When any exception or interrupt is taken, the block copies the status word into a saved-status register and the current program counter into a saved-PC register. A write port for privileged code lets software load the status word and both shadow registers. A configuration input chooses whether an accepted interrupt raises the mask field to its own priority.

Exception kind and interrupt acceptance are combinational outputs, valid in the cycle of the request. All register updates land at the next rising clock edge.

Top module: `psr_unit`

## Requirements
- R1: The status word keeps only these fields: FPU-off flag at bit 15, M at bit 9, Q at bit 8, interrupt mask at bits 7:4, S at bit 1 and T at bit 0. All other bits read as 0, and writing them has no effect (write mask 32'h0000_83F3).
- R2: After asynchronous reset `sr_o` is 32'h0000_00F0: the mask is all ones and every flag is 0.
- R3: When the FPU-off flag is 1 and a valid FPU instruction is present, `exc_kind_o` is 2'b01 (general FPU fault) if `in_slot_i` is 0 and 2'b10 (slot FPU fault) if it is 1. Otherwise no FPU fault is reported. 2'b00 means no exception and 2'b11 means an accepted interrupt.
- R4: An instruction is an FPU instruction when bits 15:12 are 4'hF. It is also one when it is a transfer to or from the FPU communication or FPU control register: bits 15:12 = 4'h4 with bits 7:0 in {8'h5A, 8'h56, 8'h6A, 8'h66, 8'h52, 8'h62}, or bits 15:12 = 4'h0 with bits 7:0 in {8'h5A, 8'h6A}.
- R5: An interrupt request is accepted (`irq_take_o` = 1, `exc_kind_o` = 2'b11) only when its level is strictly greater than the mask field. A level less than or equal to the mask is ignored.
- R6: On the edge after any entry (an FPU fault, an accepted interrupt, or `exc_entry_i`), `ssr_o` holds the status word from before the edge and `spc_o` holds `pc_i`.
- R7: At most one exception is reported per cycle. An FPU fault or an asserted `exc_entry_i` blocks interrupt acceptance in that cycle.
- R8: When `priv_i` is 0, a write request leaves SR, SSR and SPC unchanged. With `priv_i` = 1, `wr_sel_i` selects 2'b00 SR, 2'b01 SSR, 2'b10 SPC or 2'b11 nothing.
- R9: On an accepted interrupt with `imask_load_i` = 1, the mask field takes the interrupt level at the next edge. With `imask_load_i` = 0 the mask field is unchanged.
- R10: A register write requested in the same cycle as an entry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word being issued |
| instr_valid_i | input | 1 | Instruction word is valid |
| in_slot_i | input | 1 | Instruction sits in a delay slot |
| irq_req_i | input | 1 | Interrupt request |
| irq_lvl_i | input | 4 | Interrupt priority level |
| exc_entry_i | input | 1 | Another exception is being entered |
| pc_i | input | 32 | Address of the current instruction |
| priv_i | input | 1 | Core is in privileged mode |
| wr_en_i | input | 1 | Register write request |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 32 | Write data |
| imask_load_i | input | 1 | Load the mask field with the accepted level |
| exc_kind_o | output | 2 | Exception kind reported this cycle |
| irq_take_o | output | 1 | Interrupt accepted this cycle |
| sr_o | output | 32 | Status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |

## Verification
The checks assume that `exc_entry_i` and an instruction can arrive together, and that the core raises `irq_req_i` only with a defined level. The shadow registers are read only after some entry has loaded them. The random stimulus draws instructions from a weighted mix of plain FPU opcodes, FPU-register transfers and ordinary opcodes. It sets the FPU-off flag and the mask field through privileged writes. Levels are drawn across the full 4-bit range so that the equal-to-mask boundary is hit often. The shadow registers are compared only once the bench's own model has seen an entry.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned SR_W = 32;
  localparam int unsigned LVL_W = 4;
  localparam int unsigned FD_BIT = 15;
  localparam int unsigned IM_LO = 4;
  localparam logic [SR_W-1:0] SR_WMASK = 32'h0000_83F3;
  localparam logic [SR_W-1:0] SR_RESET = 32'h0000_00F0;

  typedef enum logic [1:0] {
    EXC_NONE = 2'b00,
    EXC_FPU_GEN = 2'b01,
    EXC_FPU_SLOT = 2'b10,
    EXC_IRQ = 2'b11
  } exc_kind_e;

  typedef enum logic [1:0] {
    WSEL_SR = 2'b00,
    WSEL_SSR = 2'b01,
    WSEL_SPC = 2'b10,
    WSEL_NONE = 2'b11
  } wr_sel_e;
endpackage

// File: rtl/psr_fpu_detect.sv
module psr_fpu_detect #(
  parameter int unsigned IW = 16,
  parameter bit XFER_AS_FPU = 1'b1
) (
  input  logic [IW-1:0] instr_i,
  input  logic          valid_i,
  input  logic          fd_i,
  input  logic          slot_i,
  output logic          gen_fault_o,
  output logic          slot_fault_o
);
  localparam int unsigned TOP = IW - 4;

  logic [3:0] major;
  logic [7:0] minor;
  logic       arith_op;
  logic       xfer_op;
  logic       fpu_op;

  assign major = instr_i[IW-1:TOP];
  assign minor = instr_i[7:0];
  assign arith_op = (major == 4'hF);

  generate
    if (XFER_AS_FPU) begin : g_xfer
      logic ld_form;
      logic st_form;
      always_comb begin
        ld_form = 1'b0;
        st_form = 1'b0;
        if (major == 4'h4) begin
          unique case (minor)
            8'h5A, 8'h56, 8'h6A, 8'h66, 8'h52, 8'h62: ld_form = 1'b1;
            default: ld_form = 1'b0;
          endcase
        end
        if (major == 4'h0) begin
          st_form = (minor == 8'h5A) || (minor == 8'h6A);
        end
      end
      assign xfer_op = ld_form | st_form;
    end else begin : g_noxfer
      assign xfer_op = 1'b0;
    end
  endgenerate

  if (IW > 12) begin : g_unused
    logic unused_mid;
    assign unused_mid = ^instr_i[TOP-1:8];
  end

  assign fpu_op = valid_i & (arith_op | xfer_op);
  assign gen_fault_o = fpu_op & fd_i & ~slot_i;
  assign slot_fault_o = fpu_op & fd_i & slot_i;
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
  parameter int unsigned LW = 4
) (
  input  logic          req_i,
  input  logic [LW-1:0] lvl_i,
  input  logic [LW-1:0] mask_i,
  input  logic          block_i,
  output logic          take_o
);
  // strictly above mask; equal level stays masked
  assign take_o = req_i & (lvl_i > mask_i) & ~block_i;
endmodule

// File: rtl/psr_regs.sv
module psr_regs
  import psr_pkg::*;
#(
  parameter int unsigned PCW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic             irq_take_i,
  input  logic             imask_load_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic [PCW-1:0]   pc_i,
  input  logic             wr_ok_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [SR_W-1:0]  wr_data_i,
  output logic [SR_W-1:0]  sr_o,
  output logic [SR_W-1:0]  ssr_o,
  output logic [PCW-1:0]   spc_o
);
  logic [SR_W-1:0] sr_q, sr_d;
  logic [SR_W-1:0] ssr_q;
  logic [PCW-1:0]  spc_q;
  logic            do_wr;

  assign do_wr = wr_ok_i & ~entry_i;

  always_comb begin
    sr_d = sr_q;
    if (entry_i) begin
      if (irq_take_i && imask_load_i) sr_d[IM_LO +: LVL_W] = irq_lvl_i;
    end else if (do_wr && wr_sel_i == WSEL_SR) begin
      sr_d = wr_data_i & SR_WMASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= SR_RESET;
    else         sr_q <= sr_d;
  end

  // shadow registers carry no reset value
  always_ff @(posedge clk_i) begin
    if (entry_i) begin
      ssr_q <= sr_q;
      spc_q <= pc_i;
    end else if (do_wr) begin
      if (wr_sel_i == WSEL_SSR) ssr_q <= wr_data_i;
      if (wr_sel_i == WSEL_SPC) spc_q <= wr_data_i[PCW-1:0];
    end
  end

  assign sr_o = sr_q;
  assign ssr_o = ssr_q;
  assign spc_o = spc_q;
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] instr_i,
  input  logic        instr_valid_i,
  input  logic        in_slot_i,
  input  logic        irq_req_i,
  input  logic [3:0]  irq_lvl_i,
  input  logic        exc_entry_i,
  input  logic [31:0] pc_i,
  input  logic        priv_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        imask_load_i,
  output logic [1:0]  exc_kind_o,
  output logic        irq_take_o,
  output logic [31:0] sr_o,
  output logic [31:0] ssr_o,
  output logic [31:0] spc_o
);
  logic gen_f, slot_f, take, entry;
  exc_kind_e kind;

  psr_fpu_detect #(.IW(16), .XFER_AS_FPU(1'b1)) u_det (
    .instr_i(instr_i), .valid_i(instr_valid_i), .fd_i(sr_o[FD_BIT]),
    .slot_i(in_slot_i), .gen_fault_o(gen_f), .slot_fault_o(slot_f)
  );

  psr_irq_gate #(.LW(LVL_W)) u_gate (
    .req_i(irq_req_i), .lvl_i(irq_lvl_i), .mask_i(sr_o[IM_LO +: LVL_W]),
    .block_i(gen_f | slot_f | exc_entry_i), .take_o(take)
  );

  always_comb begin
    if (slot_f)     kind = EXC_FPU_SLOT;
    else if (gen_f) kind = EXC_FPU_GEN;
    else if (take)  kind = EXC_IRQ;
    else            kind = EXC_NONE;
  end

  assign entry = gen_f | slot_f | take | exc_entry_i;

  psr_regs #(.PCW(32)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .entry_i(entry), .irq_take_i(take),
    .imask_load_i(imask_load_i), .irq_lvl_i(irq_lvl_i), .pc_i(pc_i),
    .wr_ok_i(wr_en_i & priv_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .sr_o(sr_o), .ssr_o(ssr_o), .spc_o(spc_o)
  );

  assign exc_kind_o = kind;
  assign irq_take_o = take;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_slot_i,
  input logic        irq_req_i,
  input logic [3:0]  irq_lvl_i,
  input logic        exc_entry_i,
  input logic [31:0] pc_i,
  input logic        priv_i,
  input logic        wr_en_i,
  input logic [1:0]  exc_kind_o,
  input logic        irq_take_o,
  input logic [31:0] sr_o,
  input logic [31:0] ssr_o,
  input logic [31:0] spc_o
);
  logic entry;
  assign entry = (exc_kind_o != 2'b00) || exc_entry_i;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_o & ~32'h0000_83F3) == 32'h0); // R1
  AST_SLOT_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_kind_o == 2'b10) |-> in_slot_i); // R3
  AST_GEN_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_kind_o == 2'b01) |-> (!in_slot_i && sr_o[15])); // R3
  AST_IRQ_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (irq_req_i && irq_lvl_i > sr_o[7:4])); // R5
  AST_ONE_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (exc_kind_o == 2'b11 && !exc_entry_i)); // R7
  AST_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> (ssr_o == $past(sr_o) && spc_o == $past(pc_i))); // R6
  AST_NOPRIV_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i && !entry) |=> $stable(sr_o)); // R8
endmodule

bind psr_unit psr_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_slot_i(in_slot_i), .irq_req_i(irq_req_i),
  .irq_lvl_i(irq_lvl_i), .exc_entry_i(exc_entry_i), .pc_i(pc_i), .priv_i(priv_i),
  .wr_en_i(wr_en_i), .exc_kind_o(exc_kind_o), .irq_take_o(irq_take_o),
  .sr_o(sr_o), .ssr_o(ssr_o), .spc_o(spc_o)
);

// File: tb/sim_psr_unit.sv
`timescale 1ns/1ps
module sim_psr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        ivalid = 1'b0, slot = 1'b0, irq = 1'b0, ent = 1'b0;
  logic [3:0]  lvl = '0;
  logic [31:0] pc = '0, wdata = '0;
  logic        priv = 1'b0, wen = 1'b0, ld = 1'b0;
  logic [1:0]  wsel = 2'b11;
  logic [1:0]  kind;
  logic        take;
  logic [31:0] sr, ssr, spc;

  int unsigned nvec = 0, nbad = 0;
  logic [31:0] m_sr, m_ssr, m_spc;
  bit          m_saved = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  psr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .instr_valid_i(ivalid),
    .in_slot_i(slot), .irq_req_i(irq), .irq_lvl_i(lvl), .exc_entry_i(ent),
    .pc_i(pc), .priv_i(priv), .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdata),
    .imask_load_i(ld), .exc_kind_o(kind), .irq_take_o(take),
    .sr_o(sr), .ssr_o(ssr), .spc_o(spc)
  );

  function automatic bit f_fpu(input logic [15:0] w);
    logic [7:0] lo;
    lo = w[7:0];
    if (w[15:12] == 4'hF) return 1'b1;
    if (w[15:12] == 4'h4 && (lo == 8'h5A || lo == 8'h56 || lo == 8'h6A ||
        lo == 8'h66 || lo == 8'h52 || lo == 8'h62)) return 1'b1;
    if (w[15:12] == 4'h0 && (lo == 8'h5A || lo == 8'h6A)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [15:0] i_w, input logic i_v, input logic i_s,
                      input logic i_q, input logic [3:0] i_l, input logic i_e,
                      input logic [31:0] i_pc, input logic i_p, input logic i_we,
                      input logic [1:0] i_ws, input logic [31:0] i_wd, input logic i_ld);
    logic fault_g, fault_s, tk, entry;
    logic [1:0] ek;
    logic [31:0] n_sr;
    @(negedge clk);
    instr = i_w; ivalid = i_v; slot = i_s; irq = i_q; lvl = i_l; ent = i_e;
    pc = i_pc; priv = i_p; wen = i_we; wsel = i_ws; wdata = i_wd; ld = i_ld;
    #1;
    fault_g = i_v && f_fpu(i_w) && m_sr[15] && !i_s;
    fault_s = i_v && f_fpu(i_w) && m_sr[15] && i_s;
    tk = i_q && (i_l > m_sr[7:4]) && !fault_g && !fault_s && !i_e;
    ek = fault_s ? 2'b10 : fault_g ? 2'b01 : tk ? 2'b11 : 2'b00;
    chk(fault_g || fault_s ? "R3 R4 kind" : tk ? "R5 R7 kind" : "R5 R7 none",
        {30'b0, kind}, {30'b0, ek});
    chk("R5 R7 take", {31'b0, take}, {31'b0, tk});
    entry = fault_g || fault_s || tk || i_e;
    n_sr = m_sr;
    if (entry) begin
      m_ssr = m_sr; m_spc = i_pc; m_saved = 1'b1;
      if (tk && i_ld) n_sr[7:4] = i_l;
    end else if (i_p && i_we) begin
      if (i_ws == 2'b00) n_sr = i_wd & 32'h0000_83F3;
      if (i_ws == 2'b01) m_ssr = i_wd;
      if (i_ws == 2'b10) m_spc = i_wd;
    end
    m_sr = n_sr;
    @(posedge clk); #1;
    chk("R1 R8 R9 R10 sr", sr, m_sr);
    if (m_saved) begin
      chk("R6 R8 R10 ssr", ssr, m_ssr);
      chk("R6 R8 R10 spc", spc, m_spc);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    step(16'h0009, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 1'b1, 1'b1, s, d, 1'b0);
  endtask

  function automatic logic [15:0] pick_instr(input int unsigned r);
    logic [7:0] tbl [6];
    tbl = '{8'h5A, 8'h56, 8'h6A, 8'h66, 8'h52, 8'h62};
    case (r % 5)
      0: return {4'hF, 12'($urandom)};
      1: return {4'h4, 4'($urandom), tbl[$urandom % 6]};
      2: return {4'h0, 4'($urandom), ($urandom % 2) ? 8'h5A : 8'h6A};
      default: return {4'($urandom % 15), 12'($urandom)};
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_sr = 32'h0000_00F0; m_ssr = '0; m_spc = '0;
    #12;
    chk("R2 reset sr", sr, 32'h0000_00F0);
    rst_n = 1'b1;
    // R5: all masked at reset, level 15 equals mask
    step(16'h0009, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 32'h100, 1'b0, 1'b0, 2'b11, 0, 1'b1);
    // R1: reserved bits ignored on write
    wr(2'b00, 32'hFFFF_FFFF);
    wr(2'b00, 32'h0000_0035);
    // R5 boundary: level == mask (3) ignored, mask+1 accepted, R9 load
    step(16'h0009, 1'b0, 1'b0, 1'b1, 4'h3, 1'b0, 32'h200, 1'b0, 1'b0, 2'b11, 0, 1'b1);
    step(16'h0009, 1'b0, 1'b0, 1'b1, 4'h4, 1'b0, 32'h204, 1'b0, 1'b0, 2'b11, 0, 1'b1);
    // R9 no load
    step(16'h0009, 1'b0, 1'b0, 1'b1, 4'h9, 1'b0, 32'h208, 1'b0, 1'b0, 2'b11, 0, 1'b0);
    // R3/R4: FPU off, general then slot, then transfer forms
    wr(2'b00, 32'h0000_8000);
    step(16'hF12C, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h300, 1'b0, 1'b0, 2'b11, 0, 1'b0);
    step(16'hF12C, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 32'h304, 1'b0, 1'b0, 2'b11, 0, 1'b0);
    step(16'h435A, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h308, 1'b0, 1'b0, 2'b11, 0, 1'b0);
    step(16'h026A, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 32'h30C, 1'b0, 1'b0, 2'b11, 0, 1'b0);
    step(16'h435B, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h310, 1'b0, 1'b0, 2'b11, 0, 1'b0);
    // R7: FPU fault beats interrupt; exc_entry blocks interrupt
    step(16'hF000, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 32'h314, 1'b0, 1'b0, 2'b11, 0, 1'b1);
    step(16'h0009, 1'b0, 1'b0, 1'b1, 4'hF, 1'b1, 32'h318, 1'b0, 1'b0, 2'b11, 0, 1'b1);
    // R8: unprivileged writes ignored
    step(16'h0009, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 1'b0, 1'b1, 2'b00, 32'h0000_0003, 1'b0);
    step(16'h0009, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 1'b0, 1'b1, 2'b01, 32'hDEAD_BEEF, 1'b0);
    step(16'h0009, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 1'b0, 1'b1, 2'b10, 32'hCAFE_0000, 1'b0);
    // R10: write during entry dropped
    step(16'hF000, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h400, 1'b1, 1'b1, 2'b00, 32'h0, 1'b0);
    step(16'h0009, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h404, 1'b1, 1'b1, 2'b10, 32'h1234, 1'b0);
    wr(2'b01, 32'hA5A5_5A5A);
    wr(2'b10, 32'h0000_8888);
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] wd;
      wd = $urandom;
      if ($urandom % 4 == 0) wd[15] = 1'b0;
      step(pick_instr($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           4'($urandom), ($urandom % 8 == 0), $urandom, 1'($urandom),
           ($urandom % 3 == 0), 2'($urandom), wd, 1'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule